// File: doc/BRIEF.md
# Dual-Oscillator Clock Source and Halt Controller

This block holds one byte-wide control register that decides which of two oscillators (a fast one and a slow one) are running, which of them clocks the system, and whether the CPU with its watchdog, or the peripheral clock tree, is gated off. The peripheral gate leaves the time-base timer clock running, so that timer can still wake the system.

A write that would leave the selected clock without its oscillator, or stop both oscillators, is not applied. Instead the block raises a one-cycle system reset request and returns every field to its reset value. A change of main clock is only recorded as a request. The active selection follows once the target oscillator reports ready, and the readback shows the clock actually in use. An interrupt wake clears both halt bits in hardware. A write that asks for both halts at once leaves the halt bits alone and sets a sticky error flag.

Top module: `clkctl_top`

## Requirements
- R1: After rst_n is asserted, rd_data reads 8'h80: fast oscillator enabled (bit 7), slow oscillator disabled (bit 6), fast clock selected (bit 5 = 0), both halt bits clear, sys_rst_req = 0, halt_combo_err = 0.
- R2: A legal write loads bit 7 into hf_osc_en and bit 6 into lf_osc_en at the next clock edge, and both read back at the same positions.
- R3: A write is illegal when bits 7 and 6 are both 0, when bit 7 is 0 while the fast clock is active (clk_sel = 0), or when bit 6 is 0 while the slow clock is active (clk_sel = 1). An illegal write is not applied. At the next edge sys_rst_req is 1 for that cycle and all fields, including the error flag, return to their R1 values.
- R4: Bit 5 of a write requests a main clock (0 = fast, 1 = slow). clk_sel and rd_data bit 5 change to the requested value one edge after the request is held, and only on an edge where the target's ready input (hf_ready or lf_ready) is 1. Until then they keep the old source.
- R5: Writing 1 to bit 4 sets cpu_clk_stop at the next edge; writing 0 to bit 4 clears it. rd_data bit 4 mirrors it.
- R6: Writing 1 to bit 2 sets periph_clk_stop at the next edge; writing 0 to bit 2 clears it. rd_data bit 2 mirrors it.
- R7: A wake_irq pulse clears both halt bits at the next edge. This takes priority over a write in the same cycle.
- R8: A write with bits 4 and 2 both 1 leaves both halt bits unchanged, still applies bits 7..5, and sets halt_combo_err. The flag stays set until a reset, and the two halt bits are never 1 together.
- R9: rd_data bits 3, 1 and 0 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| hf_ready | input | 1 | Fast oscillator is stable |
| lf_ready | input | 1 | Slow oscillator is stable |
| wake_irq | input | 1 | Enabled interrupt request pulse |
| rd_data | output | 8 | Register readback with the active clock in bit 5 |
| hf_osc_en | output | 1 | Fast oscillator enable |
| lf_osc_en | output | 1 | Slow oscillator enable |
| clk_sel | output | 1 | Active main clock, 1 = slow |
| cpu_clk_stop | output | 1 | Gate for the CPU and watchdog clocks |
| periph_clk_stop | output | 1 | Gate for the peripheral clocks, time-base timer excluded |
| sys_rst_req | output | 1 | One-cycle reset request after an illegal write |
| halt_combo_err | output | 1 | Sticky flag for a write that set both halt bits |

## Verification
The assertion that the active clock's oscillator is always enabled relies on a ready input rising only while its own oscillator is enabled. The stimulus therefore raises lf_ready only after bit 6 has been written as 1, and lowers hf_ready whenever the fast oscillator is off. The wake and halt properties assume wake_irq is a clean synchronous pulse, so the bench changes it only on the falling edge, together with the write strobe.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_HF    = 7;
  localparam int unsigned B_LF    = 6;
  localparam int unsigned B_SEL   = 5;
  localparam int unsigned B_CPU   = 4;
  localparam int unsigned B_PER   = 2;

  typedef struct packed {
    logic hf_en;
    logic lf_en;
    logic sel_req;
  } osc_cfg_t;

  localparam osc_cfg_t CFG_RST = '{hf_en: 1'b1, lf_en: 1'b0, sel_req: 1'b0};
endpackage

// File: rtl/clkctl_guard.sv
module clkctl_guard (
  input  logic wr_en,
  input  logic new_hf,
  input  logic new_lf,
  input  logic sel_act,
  output logic illegal
);
  logic both_off, kill_fast, kill_slow;

  always_comb begin
    both_off  = !new_hf && !new_lf;
    kill_fast = !new_hf && !sel_act;
    kill_slow = !new_lf &&  sel_act;
    illegal   = wr_en && (both_off || kill_fast || kill_slow);
  end
endmodule

// File: rtl/clkctl_selsw.sv
module clkctl_selsw (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel_req,
  input  logic hf_ready,
  input  logic lf_ready,
  output logic sel_act
);
  logic tgt_ready;
  logic sel_nxt;

  always_comb begin
    tgt_ready = sel_req ? lf_ready : hf_ready;
    sel_nxt   = sel_act;
    if (clr)
      sel_nxt = 1'b0;
    else if ((sel_req != sel_act) && tgt_ready)
      sel_nxt = sel_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_act <= 1'b0;
    else        sel_act <= sel_nxt;
  end

  // R4: no switch while the target oscillator is not ready
  a_r4_wait_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (sel_req != sel_act) && !tgt_ready) |=> $stable(sel_act));
endmodule

// File: rtl/clkctl_halt.sv
module clkctl_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_en,
  input  logic wr_cpu,
  input  logic wr_per,
  input  logic wake,
  output logic cpu_halt,
  output logic per_halt,
  output logic combo_hit
);
  logic cpu_nxt, per_nxt;

  always_comb begin
    combo_hit = wr_en && wr_cpu && wr_per;
    cpu_nxt   = cpu_halt;
    per_nxt   = per_halt;
    if (clr || wake) begin
      cpu_nxt = 1'b0;
      per_nxt = 1'b0;
    end else if (wr_en && !combo_hit) begin
      cpu_nxt = wr_cpu;
      per_nxt = wr_per;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_halt <= 1'b0;
      per_halt <= 1'b0;
    end else begin
      cpu_halt <= cpu_nxt;
      per_halt <= per_nxt;
    end
  end

  a_r7_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (!cpu_halt && !per_halt));
  a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_halt && per_halt));
  a_r5_cpu_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cpu && !wr_per && !wake && !clr) |=> cpu_halt);
  a_r6_per_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_per && !wr_cpu && !wake && !clr) |=> per_halt);
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          hf_ready,
  input  logic          lf_ready,
  input  logic          wake_irq,
  output logic [DW-1:0] rd_data,
  output logic          hf_osc_en,
  output logic          lf_osc_en,
  output logic          clk_sel,
  output logic          cpu_clk_stop,
  output logic          periph_clk_stop,
  output logic          sys_rst_req,
  output logic          halt_combo_err
);
  osc_cfg_t cfg_q, cfg_d;
  logic     err_d;
  logic     illegal;
  logic     sel_act;
  logic     cpu_halt, per_halt, combo_hit;
  logic     unused_bits;

  assign unused_bits = ^{wr_data[3], wr_data[1:0]};

  clkctl_guard u_guard (
    .wr_en   (wr_en),
    .new_hf  (wr_data[B_HF]),
    .new_lf  (wr_data[B_LF]),
    .sel_act (sel_act),
    .illegal (illegal)
  );

  clkctl_selsw u_selsw (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (illegal),
    .sel_req  (cfg_q.sel_req),
    .hf_ready (hf_ready),
    .lf_ready (lf_ready),
    .sel_act  (sel_act)
  );

  clkctl_halt u_halt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (illegal),
    .wr_en     (wr_en),
    .wr_cpu    (wr_data[B_CPU]),
    .wr_per    (wr_data[B_PER]),
    .wake      (wake_irq),
    .cpu_halt  (cpu_halt),
    .per_halt  (per_halt),
    .combo_hit (combo_hit)
  );

  always_comb begin
    cfg_d = cfg_q;
    err_d = halt_combo_err;
    if (illegal) begin
      cfg_d = CFG_RST;
      err_d = 1'b0;
    end else begin
      if (wr_en) begin
        cfg_d.hf_en   = wr_data[B_HF];
        cfg_d.lf_en   = wr_data[B_LF];
        cfg_d.sel_req = wr_data[B_SEL];
      end
      if (combo_hit) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q          <= CFG_RST;
      halt_combo_err <= 1'b0;
      sys_rst_req    <= 1'b0;
    end else begin
      cfg_q          <= cfg_d;
      halt_combo_err <= err_d;
      sys_rst_req    <= illegal;
    end
  end

  always_comb begin
    rd_data        = '0;
    rd_data[B_HF]  = cfg_q.hf_en;
    rd_data[B_LF]  = cfg_q.lf_en;
    rd_data[B_SEL] = sel_act;
    rd_data[B_CPU] = cpu_halt;
    rd_data[B_PER] = per_halt;
  end

  assign hf_osc_en       = cfg_q.hf_en;
  assign lf_osc_en       = cfg_q.lf_en;
  assign clk_sel         = sel_act;
  assign cpu_clk_stop    = cpu_halt;
  assign periph_clk_stop = per_halt;

  a_r3_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> (hf_osc_en && !lf_osc_en && !clk_sel && !cpu_clk_stop && !periph_clk_stop));
  a_r3_active_osc_on: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel ? lf_osc_en : hf_osc_en));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_combo_err && !illegal) |=> halt_combo_err);
  a_r9_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] == 1'b0) && (rd_data[1:0] == 2'b00));
endmodule

// File: tb/test_clkctl_top.sv
module test_clkctl_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, hf_ready, lf_ready, wake_irq;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       hf_osc_en, lf_osc_en, clk_sel, cpu_clk_stop, periph_clk_stop;
  logic       sys_rst_req, halt_combo_err;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  clkctl_top i_clkctl_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hf_ready(hf_ready), .lf_ready(lf_ready), .wake_irq(wake_irq),
    .rd_data(rd_data), .hf_osc_en(hf_osc_en), .lf_osc_en(lf_osc_en),
    .clk_sel(clk_sel), .cpu_clk_stop(cpu_clk_stop), .periph_clk_stop(periph_clk_stop),
    .sys_rst_req(sys_rst_req), .halt_combo_err(halt_combo_err)
  );

  // {wr_en, wr_data, hf_ready, lf_ready, wake, exp_rd, exp_rst, exp_err}
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 8'hC0, 1'b1, 1'b0, 1'b0, 8'hC0, 1'b0, 1'b0}, // R2 both on
    {1'b1, 8'hE0, 1'b1, 1'b0, 1'b0, 8'hC0, 1'b0, 1'b0}, // R4 request slow
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC0, 1'b0, 1'b0}, // R4 not ready
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hE0, 1'b0, 1'b0}, // R4 switch
    {1'b1, 8'hF0, 1'b1, 1'b1, 1'b0, 8'hF0, 1'b0, 1'b0}, // R5 cpu halt
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'hE0, 1'b0, 1'b0}, // R7 wake
    {1'b1, 8'hE4, 1'b1, 1'b1, 1'b0, 8'hE4, 1'b0, 1'b0}, // R6 periph halt
    {1'b1, 8'hE4, 1'b1, 1'b1, 1'b1, 8'hE0, 1'b0, 1'b0}, // R7 wake beats write
    {1'b1, 8'hF4, 1'b1, 1'b1, 1'b0, 8'hE0, 1'b0, 1'b1}, // R8 both halts
    {1'b1, 8'h6B, 1'b0, 1'b1, 1'b0, 8'h60, 1'b0, 1'b1}, // R9 R2 fast off
    {1'b1, 8'h20, 1'b0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0}, // R3 both off
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0}, // R3 pulse ends
    {1'b1, 8'hC0, 1'b1, 1'b0, 1'b0, 8'hC0, 1'b0, 1'b0}, // R2
    {1'b1, 8'h40, 1'b1, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0}, // R3 active fast off
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0}, // R3
    {1'b1, 8'hE0, 1'b1, 1'b1, 1'b0, 8'hC0, 1'b0, 1'b0}, // R4 request
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hE0, 1'b0, 1'b0}, // R4 switched
    {1'b1, 8'hA0, 1'b1, 1'b1, 1'b0, 8'h80, 1'b1, 1'b0}  // R3 active slow off
  };

  task automatic check(input string req, input logic [7:0] erd,
                       input logic erst, input logic eerr);
    logic [7:0] act_o, exp_o;
    act_o = {hf_osc_en, lf_osc_en, clk_sel, cpu_clk_stop, 1'b0, periph_clk_stop, sys_rst_req, halt_combo_err};
    exp_o = {erd[7], erd[6], erd[5], erd[4], 1'b0, erd[2], erst, eerr};
    n_chk++;
    if (rd_data !== erd || act_o !== exp_o) begin
      n_bad++;
      $display("FAIL %s: rd=%h outs=%b expected rd=%h outs=%b", req, rd_data, act_o, erd, exp_o);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d, input logic hr,
                      input logic lr, input logic wk);
    @(negedge clk);
    wr_en = we; wr_data = d; hf_ready = hr; lf_ready = lr; wake_irq = wk;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    hf_ready = 1'b1; lf_ready = 1'b0; wake_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 8'h80, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20:13], VEC[i][12], VEC[i][11], VEC[i][10]);
      check($sformatf("vector %0d (R2..R9)", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R8: combo write with cpu halt already set keeps it set
    step(1'b1, 8'h90, 1'b1, 1'b0, 1'b0);
    check("R5 cpu halt", 8'h90, 1'b0, 1'b0);
    step(1'b1, 8'h94, 1'b1, 1'b0, 1'b0);
    check("R8 combo keeps halt", 8'h90, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R8 flag sticky", 8'h90, 1'b0, 1'b1);
    // R7: wake on its own clears the cpu halt
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    check("R7 wake alone", 8'h80, 1'b0, 1'b1);
    // R1: external reset clears the sticky flag
    @(negedge clk);
    wake_irq = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 8'h80, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule